// File: doc/BRIEF.md
# Multi-Mode Fast Output Bank

This block holds the output state of a small bank of fast GPIO channels and lets software change that state in several ways. Through the register bus it accepts a whole-word write, a combined value-and-mask write, or a word of 2-bit per-channel commands (set, clear, toggle, no-op). A separate core-side write port lets a processor drive channels directly, but only those channels that a software-programmed enable mask releases to it. The present output state can be read back at any time.

Every write lands on the clock edge that samples its strobe. When a bus write and a core-port write arrive in the same cycle, the bus write takes the channels it touches, and the core port still updates the other enabled channels. The output flops drive the channel pins directly.

Top module: `fast_out_bank`

## Requirements
- R1: During and after reset every channel output is 0 and the core-access enable mask is 0.
- R2: A bus write to address 0 loads bits [7:0] of the write data into the channel outputs on the next clock edge, replacing every channel.
- R3: A bus write to address 1 treats bits [7:0] as values and bits [15:8] as a mask; on the next edge only channels whose mask bit is 1 take their value bit, and the others keep their state.
- R4: A bus write to address 2 gives channel n the command field at bits [2n+1:2n]; code 1 sets it, code 2 clears it, code 3 inverts it and code 0 leaves it unchanged, so several channels can be commanded in one write.
- R5: Address 3 holds the core-access enable mask in bits [7:0]; a write loads it on the next edge and a read returns it with the upper bits 0.
- R6: A core-port write updates on the next edge only the channels whose enable bit is 1; disabled channels keep their state.
- R7: If a bus write and a core-port write occur in the same cycle, the channels affected by the bus write take the bus result and the remaining enabled channels take the core data. A write to the enable register affects no channel, and the core write in that cycle uses the enable mask held before it.
- R8: A read of address 4 returns the current output state in bits [7:0] with the upper bits 0; read data follows the address in the same cycle.
- R9: Bus writes to address 4 or to any unmapped address change neither the outputs nor the enable mask, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Bus write strobe |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Bus read data, combinational from address |
| coreWrEn | input | 1 | Core-side write strobe |
| coreWrData | input | 8 | Core-side channel values |
| chanOut | output | 8 | Channel output state |

## Verification
Directed cases first walk each write mechanism alone: all-ones and alternating word writes, masked writes with empty, full and sparse masks, and command words that mix all four codes across channels, which separates set, clear and toggle from the no-op code. Core-port writes are tried with empty, partial and full enable masks so that gating faults show up on disabled channels. Same-cycle collisions of the core port with each bus mechanism tell the bus-priority rule apart from a plain merge, and a random mix of all operations, including unmapped addresses, compares every cycle against a bench model.

// File: rtl/fast_out_pkg.sv
package fast_out_pkg;
  localparam int unsigned ADDR_WORD = 0;
  localparam int unsigned ADDR_MASK = 1;
  localparam int unsigned ADDR_CMD  = 2;
  localparam int unsigned ADDR_EN   = 3;
  localparam int unsigned ADDR_SCAN = 4;

  localparam logic [1:0] CMD_NONE   = 2'd0;
  localparam logic [1:0] CMD_SET    = 2'd1;
  localparam logic [1:0] CMD_CLEAR  = 2'd2;
  localparam logic [1:0] CMD_TOGGLE = 2'd3;

  typedef struct packed {
    logic wordWr;
    logic maskWr;
    logic cmdWr;
    logic enWr;
    logic scanRd;
    logic enRd;
  } ctrlStrobes_t;
endpackage

// File: rtl/fast_out_ctrl.sv
module fast_out_ctrl
  import fast_out_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobes_t      strobes
);
  logic hitWord, hitMask, hitCmd, hitEn, hitScan;

  always_comb begin
    hitWord = (busAddr == ADDR_W'(ADDR_WORD));
    hitMask = (busAddr == ADDR_W'(ADDR_MASK));
    hitCmd  = (busAddr == ADDR_W'(ADDR_CMD));
    hitEn   = (busAddr == ADDR_W'(ADDR_EN));
    hitScan = (busAddr == ADDR_W'(ADDR_SCAN));
  end

  always_comb begin
    strobes        = '0;
    strobes.wordWr = busWrEn & hitWord;
    strobes.maskWr = busWrEn & hitMask;
    strobes.cmdWr  = busWrEn & hitCmd;
    strobes.enWr   = busWrEn & hitEn;
    strobes.scanRd = hitScan;
    strobes.enRd   = hitEn;
  end

  // At most one write strobe per cycle (R9: unmapped writes raise none)
  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wordWr, strobes.maskWr, strobes.cmdWr, strobes.enWr}));
endmodule

// File: rtl/fast_out_datapath.sv
module fast_out_datapath
  import fast_out_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              coreWrEn,
  input  logic [NUM_CH-1:0] coreWrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] chanOut
);
  localparam int unsigned CMD_W = 2;

  logic [NUM_CH-1:0] outState, outNext;
  logic [NUM_CH-1:0] enMask;
  logic [NUM_CH-1:0] busAffect, busValue;
  logic [NUM_CH-1:0] cmdAffect, cmdValue;
  logic [NUM_CH-1:0] coreAffect;

  // Per-channel command decode
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmd
    logic [CMD_W-1:0] code;
    assign code = wrData[CMD_W*ch +: CMD_W];
    always_comb begin
      cmdAffect[ch] = (code != CMD_NONE);
      unique case (code)
        CMD_SET:    cmdValue[ch] = 1'b1;
        CMD_CLEAR:  cmdValue[ch] = 1'b0;
        CMD_TOGGLE: cmdValue[ch] = ~outState[ch];
        default:    cmdValue[ch] = outState[ch];
      endcase
    end
  end

  always_comb begin
    busAffect = '0;
    busValue  = '0;
    if (strobes.wordWr) begin
      busAffect = '1;
      busValue  = wrData[NUM_CH-1:0];
    end else if (strobes.maskWr) begin
      busAffect = wrData[2*NUM_CH-1:NUM_CH];
      busValue  = wrData[NUM_CH-1:0];
    end else if (strobes.cmdWr) begin
      busAffect = cmdAffect;
      busValue  = cmdValue;
    end
    coreAffect = (coreWrEn ? enMask : '0) & ~busAffect;
    outNext = (outState & ~(busAffect | coreAffect))
            | (busValue & busAffect)
            | (coreWrData & coreAffect);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outState <= '0;
      enMask   <= '0;
    end else begin
      outState <= outNext;
      if (strobes.enWr) enMask <= wrData[NUM_CH-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.scanRd)    rdData[NUM_CH-1:0] = outState;
    else if (strobes.enRd) rdData[NUM_CH-1:0] = enMask;
  end

  assign chanOut = outState;

  // Assertions
  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (chanOut == '0) && (enMask == '0));

  assert_word_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wordWr |=> chanOut == $past(wrData[NUM_CH-1:0]));

  assert_mask_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.maskWr && !coreWrEn) |=>
      ((chanOut ^ $past(chanOut)) & ~$past(wrData[2*NUM_CH-1:NUM_CH])) == '0);

  assert_core_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrEn && !strobes.wordWr && !strobes.maskWr && !strobes.cmdWr) |=>
      ((chanOut ^ $past(chanOut)) & ~$past(enMask)) == '0);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!coreWrEn && !strobes.wordWr && !strobes.maskWr && !strobes.cmdWr) |=>
      $stable(chanOut));
endmodule

// File: rtl/fast_out_bank.sv
module fast_out_bank
  import fast_out_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              coreWrEn,
  input  logic [NUM_CH-1:0] coreWrData,
  output logic [NUM_CH-1:0] chanOut
);
  ctrlStrobes_t strobes;

  fast_out_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  fast_out_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (busWrData),
    .coreWrEn   (coreWrEn),
    .coreWrData (coreWrData),
    .rdData     (busRdData),
    .chanOut    (chanOut)
  );
endmodule

// File: tb/tb_fast_out_bank.sv
module tb_fast_out_bank;
  localparam int N = 8;

  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  busAddr = 0;
  logic        busWrEn = 0;
  logic [31:0] busWrData = 0;
  logic [31:0] busRdData;
  logic        coreWrEn = 0;
  logic [7:0]  coreWrData = 0;
  logic [7:0]  chanOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] mState = 0;
  logic [7:0] mEn = 0;

  always #5 clk = ~clk;

  fast_out_bank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .coreWrEn(coreWrEn),
    .coreWrData(coreWrData), .chanOut(chanOut)
  );

  function automatic logic [7:0] modelNext(logic [7:0] st, logic [7:0] en,
      logic [3:0] a, logic we, logic [31:0] d, logic cwe, logic [7:0] cd);
    logic [7:0] aff = 0, val = 0, core;
    if (we && a == 0) begin aff = 8'hFF; val = d[7:0]; end
    else if (we && a == 1) begin aff = d[15:8]; val = d[7:0]; end
    else if (we && a == 2) begin
      for (int c = 0; c < N; c++) begin
        case (d[2*c +: 2])
          2'd1: begin aff[c] = 1; val[c] = 1; end
          2'd2: begin aff[c] = 1; val[c] = 0; end
          2'd3: begin aff[c] = 1; val[c] = ~st[c]; end
          default: ;
        endcase
      end
    end
    core = cwe ? (en & ~aff) : 8'h00;
    return (st & ~(aff | core)) | (val & aff) | (cd & core);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(string req, logic [3:0] a, logic we, logic [31:0] d,
                    logic cwe, logic [7:0] cd);
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = d; coreWrEn = cwe; coreWrData = cd;
    @(posedge clk);
    mState = modelNext(mState, mEn, a, we, d, cwe, cd);
    if (we && a == 3) mEn = d[7:0];
    #1;
    busWrEn = 0; coreWrEn = 0; busAddr = 4;
    #1;
    check(req, {24'h0, chanOut}, {24'h0, mState});
    check("R8", busRdData, {24'h0, mState});
  endtask

  task automatic readChk(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busWrEn = 0; coreWrEn = 0;
    #1;
    check(req, busRdData, exp);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {24'h0, chanOut}, 32'h0);
    rstN = 1;
    readChk("R1", 3, 32'h0);
    readChk("R8", 4, 32'h0);

    // R2 word writes
    op("R2", 0, 1, 32'hFFFF_FFA5, 0, 0);
    op("R2", 0, 1, 32'h0000_005A, 0, 0);
    // R3 masked writes
    op("R3", 1, 1, 32'h0000_00FF, 0, 0);
    op("R3", 1, 1, 32'h0000_FF00, 0, 0);
    op("R3", 1, 1, 32'h0000_81F0, 0, 0);
    // R4 mixed commands: ch0 set, ch1 clear, ch2 toggle, ch3 none
    op("R4", 2, 1, 32'h0000_0039, 0, 0);
    op("R4", 2, 1, 32'h0000_FFFF, 0, 0);
    op("R4", 2, 1, 32'h0000_5555, 0, 0);
    op("R4", 2, 1, 32'h0000_AAAA, 0, 0);
    // R5 enable register
    op("R5", 3, 1, 32'hFFFF_FF3C, 0, 0);
    readChk("R5", 3, 32'h0000_003C);
    // R6 core port gating
    op("R6", 0, 0, 0, 1, 8'hFF);
    op("R6", 0, 0, 0, 1, 8'h00);
    // R7 collisions
    op("R7", 1, 1, 32'h0000_0C00, 1, 8'hFF);
    op("R7", 2, 1, 32'h0000_0020, 1, 8'h00);
    op("R7", 0, 1, 32'h0000_0081, 1, 8'h7E);
    op("R7", 3, 1, 32'h0000_00FF, 1, 8'hFF);
    op("R7", 0, 0, 0, 1, 8'h00);
    // R9 ignored writes
    op("R9", 4, 1, 32'hFFFF_FFFF, 0, 0);
    op("R9", 9, 1, 32'hFFFF_FFFF, 0, 0);
    readChk("R9", 3, {24'h0, mEn});
    readChk("R9", 12, 32'h0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a = 4'($urandom_range(0, 6));
      op("R7", a, 1'($urandom), $urandom, 1'($urandom), 8'($urandom));
      if (i % 50 == 0) readChk("R5", 3, {24'h0, mEn});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule